// File: doc/BRIEF.md
# Boundary-Scan Cell Chain

This block is the boundary-scan data register that sits between the core logic and the I/O pads of a device. It is a serial chain of capture cells, and some of those cells also carry update cells. The chain handles three kinds of pin.

- A general-purpose bidirectional pin has three cells. They cover the pad input, the output value and the output enable.
- A configuration or reset pin has one observe-only cell. That cell can read the pad but never drives it.
- A memory-interface pin has two cells. One is a shared bidirectional data cell and the other is an output-enable cell.

A test access port controller, which is outside this block, supplies four strobes, all sampled on the rising edge of `clk`:

- a clock enable for the data register (`capture_dr`);
- a shift select (`shift_dr`);
- an update strobe (`update_dr`);
- a mode level (`extest`).

The controller also supplies the serial input `tdi` and reads the serial output `tdo`.

With `extest` low, the pads carry the core signals unchanged. In this mode the chain can sample the pins or preload patterns without disturbing normal operation. With `extest` high, every driving pad takes its value from the update cells. The update cells are loaded from the capture cells on `update_dr`, so the tester controls the board-level nets directly.

The number of pins of each kind is set by parameters, and each count must be at least 1. The chain length is derived as N = 3·N_GPIO + N_CFG + 2·N_MEM. Bit 0 is the cell nearest `tdo`.

Top module: `bscan_chain`

## Requirements
- R1: Chain layout, from bit 0 (the `tdo` end) upward:
  - general-purpose pin g at bits 3g (pad input), 3g+1 (output) and 3g+2 (output enable);
  - then configuration pin c at bit 3·N_GPIO+c;
  - then memory pin m at bits B+2m (data) and B+2m+1 (output enable), where B = 3·N_GPIO+N_CFG.

  `tdo` always shows bit 0. On a clock edge with `capture_dr`=1 and `shift_dr`=1, every bit moves one place toward bit 0 and `tdi` enters bit N-1. After N such edges, the first bit shifted in sits at bit 0.
- R2: On an edge with `capture_dr`=1 and `shift_dr`=0, each general-purpose pin's cells load `pad_gpio_in`, `core_gpio_out` and `core_gpio_oe`, whatever the value of `extest`.
- R3: On the same capture edge, each configuration cell loads `pad_cfg_in`. No output of the block depends on these cells except `tdo`.
- R4: On a capture edge with `extest`=0, a memory pin's data cell loads `pad_mem_in`. On any capture edge, its output-enable cell loads `core_mem_oe`.
- R5: On a capture edge with `extest`=1, a memory pin's data cell keeps its previous content; the pad input is not sampled.
- R6: On an edge with `update_dr`=1, each driving cell's update flop takes the value its capture flop held before that edge. The driving cells are the general-purpose output and enable cells and the memory data and enable cells. The update flops change on no other edge, including shift edges.
- R7: With `extest`=0, `pad_gpio_out`, `pad_gpio_oe`, `pad_mem_out` and `pad_mem_oe` equal `core_gpio_out`, `core_gpio_oe`, `core_mem_out` and `core_mem_oe` in the same cycle.
- R8: With `extest`=1, those pad outputs equal the update flops of the matching cells. They stay unchanged while core inputs change, until the next update edge.
- R9: A synchronous active-high `rst` clears all capture and update flops. Afterwards `tdo` is 0, and with `extest`=1 every pad output and enable is 0.
- R10: On edges with `capture_dr`=0, the capture flops hold their contents, whatever the pad and core inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all flops use its rising edge |
| rst | input | 1 | Synchronous active-high test-logic reset |
| capture_dr | input | 1 | Data-register clock enable (capture or shift) |
| shift_dr | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| update_dr | input | 1 | Loads the update flops from the capture flops |
| extest | input | 1 | 1 makes the pads take the update flops, 0 makes them take the core |
| tdi | input | 1 | Serial data into bit N-1 |
| tdo | output | 1 | Serial data from bit 0 |
| core_gpio_out | input | N_GPIO | Core output values for general-purpose pins |
| core_gpio_oe | input | N_GPIO | Core output enables for general-purpose pins |
| pad_gpio_in | input | N_GPIO | Pad input values of general-purpose pins |
| pad_gpio_out | output | N_GPIO | Values to the general-purpose pad buffers |
| pad_gpio_oe | output | N_GPIO | Enables to the general-purpose pad buffers |
| pad_cfg_in | input | N_CFG | Observed states of configuration and reset pins |
| core_mem_out | input | N_MEM | Core output values for memory pins |
| core_mem_oe | input | N_MEM | Core output enables for memory pins |
| pad_mem_in | input | N_MEM | Pad input values of memory pins |
| pad_mem_out | output | N_MEM | Values to the memory pad buffers |
| pad_mem_oe | output | N_MEM | Enables to the memory pad buffers |

## Verification
A wrong capture or shift register shows up only at `tdo`, and only after the chain has been shifted up to that cell's position. The bench therefore shifts full frames and compares every bit against a model of the register contents. A misplaced cell gives a wrong bit at a definite position. A missing hold on the memory data cell under EXTEST shows the pad value where the preloaded bit was expected.

A wrong update flop is visible at the pads as soon as `extest` is high, and it must stay frozen across shifts and core changes. A faulty mode multiplexer breaks the pad-equals-core comparison in the same cycle.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  // Cells per pin kind and each cell's offset within its pin
  localparam int GP_CELLS  = 3;
  localparam int MEM_CELLS = 2;
  localparam int GP_IN     = 0;
  localparam int GP_OUT    = 1;
  localparam int GP_OE     = 2;
  localparam int MEM_IO    = 0;
  localparam int MEM_OE    = 1;

  function automatic int chain_len(int ng, int nc, int nm);
    return ng * GP_CELLS + nc + nm * MEM_CELLS;
  endfunction

  function automatic int cfg_base(int ng);
    return ng * GP_CELLS;
  endfunction

  function automatic int mem_base(int ng, int nc);
    return ng * GP_CELLS + nc;
  endfunction
endpackage

// File: rtl/bscan_obs_cell.sv
// Observe-only cell: a capture/shift flop, no update stage
module bscan_obs_cell (
  input  logic clk,
  input  logic rst,
  input  logic clk_dr,
  input  logic shift,
  input  logic par_in,
  input  logic ser_in,
  output logic cap_q
);
  always_ff @(posedge clk) begin
    if (rst)
      cap_q <= 1'b0;
    else if (clk_dr)
      cap_q <= shift ? ser_in : par_in;
  end
endmodule

// File: rtl/bscan_drv_cell.sv
// Driving cell: capture/shift flop, update flop and pad-side mode mux
module bscan_drv_cell (
  input  logic clk,
  input  logic rst,
  input  logic clk_dr,
  input  logic shift,
  input  logic upd_dr,
  input  logic extest,
  input  logic par_in,
  input  logic ser_in,
  input  logic core_val,
  output logic cap_q,
  output logic pad_val
);
  logic upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      if (clk_dr)
        cap_q <= shift ? ser_in : par_in;
      if (upd_dr)
        upd_q <= cap_q;
    end
  end

  assign pad_val = extest ? upd_q : core_val;
endmodule

// File: rtl/bscan_gpio_pin.sv
// General-purpose pin: observe cell for the input, driving cells for value and enable
module bscan_gpio_pin
  import bscan_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                clk_dr,
  input  logic                shift,
  input  logic                upd_dr,
  input  logic                extest,
  input  logic [GP_CELLS-1:0] ser_in,
  output logic [GP_CELLS-1:0] cap_q,
  input  logic                core_out,
  input  logic                core_oe,
  input  logic                pad_in,
  output logic                pad_out,
  output logic                pad_oe
);
  bscan_obs_cell u_in (
    .clk(clk), .rst(rst), .clk_dr(clk_dr), .shift(shift),
    .par_in(pad_in), .ser_in(ser_in[GP_IN]), .cap_q(cap_q[GP_IN])
  );

  bscan_drv_cell u_out (
    .clk(clk), .rst(rst), .clk_dr(clk_dr), .shift(shift),
    .upd_dr(upd_dr), .extest(extest),
    .par_in(core_out), .ser_in(ser_in[GP_OUT]), .core_val(core_out),
    .cap_q(cap_q[GP_OUT]), .pad_val(pad_out)
  );

  bscan_drv_cell u_oe (
    .clk(clk), .rst(rst), .clk_dr(clk_dr), .shift(shift),
    .upd_dr(upd_dr), .extest(extest),
    .par_in(core_oe), .ser_in(ser_in[GP_OE]), .core_val(core_oe),
    .cap_q(cap_q[GP_OE]), .pad_val(pad_oe)
  );
endmodule

// File: rtl/bscan_mem_pin.sv
// Memory-interface pin: a shared data cell and an enable cell.
// In external-test mode the data cell keeps its own content on capture.
module bscan_mem_pin
  import bscan_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clk_dr,
  input  logic                 shift,
  input  logic                 upd_dr,
  input  logic                 extest,
  input  logic [MEM_CELLS-1:0] ser_in,
  output logic [MEM_CELLS-1:0] cap_q,
  input  logic                 core_out,
  input  logic                 core_oe,
  input  logic                 pad_in,
  output logic                 pad_out,
  output logic                 pad_oe
);
  logic io_par;

  assign io_par = extest ? cap_q[MEM_IO] : pad_in;

  bscan_drv_cell u_io (
    .clk(clk), .rst(rst), .clk_dr(clk_dr), .shift(shift),
    .upd_dr(upd_dr), .extest(extest),
    .par_in(io_par), .ser_in(ser_in[MEM_IO]), .core_val(core_out),
    .cap_q(cap_q[MEM_IO]), .pad_val(pad_out)
  );

  bscan_drv_cell u_oe (
    .clk(clk), .rst(rst), .clk_dr(clk_dr), .shift(shift),
    .upd_dr(upd_dr), .extest(extest),
    .par_in(core_oe), .ser_in(ser_in[MEM_OE]), .core_val(core_oe),
    .cap_q(cap_q[MEM_OE]), .pad_val(pad_oe)
  );
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_GPIO = 2,
  parameter int N_CFG  = 2,
  parameter int N_MEM  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              extest,
  input  logic              tdi,
  output logic              tdo,
  input  logic [N_GPIO-1:0] core_gpio_out,
  input  logic [N_GPIO-1:0] core_gpio_oe,
  input  logic [N_GPIO-1:0] pad_gpio_in,
  output logic [N_GPIO-1:0] pad_gpio_out,
  output logic [N_GPIO-1:0] pad_gpio_oe,
  input  logic [N_CFG-1:0]  pad_cfg_in,
  input  logic [N_MEM-1:0]  core_mem_out,
  input  logic [N_MEM-1:0]  core_mem_oe,
  input  logic [N_MEM-1:0]  pad_mem_in,
  output logic [N_MEM-1:0]  pad_mem_out,
  output logic [N_MEM-1:0]  pad_mem_oe
);
  localparam int LEN      = chain_len(N_GPIO, N_CFG, N_MEM);
  localparam int CFG_BASE = cfg_base(N_GPIO);
  localparam int MEM_BASE = mem_base(N_GPIO, N_CFG);

  // cap_q[0] faces tdo, serial data moves from high index toward 0
  logic [LEN-1:0] cap_q;
  logic [LEN-1:0] ser_vec;

  assign ser_vec = {tdi, cap_q[LEN-1:1]};
  assign tdo     = cap_q[0];

  for (genvar g = 0; g < N_GPIO; g++) begin : g_gpio
    bscan_gpio_pin u_pin (
      .clk     (clk),
      .rst     (rst),
      .clk_dr  (capture_dr),
      .shift   (shift_dr),
      .upd_dr  (update_dr),
      .extest  (extest),
      .ser_in  (ser_vec[g*GP_CELLS +: GP_CELLS]),
      .cap_q   (cap_q[g*GP_CELLS +: GP_CELLS]),
      .core_out(core_gpio_out[g]),
      .core_oe (core_gpio_oe[g]),
      .pad_in  (pad_gpio_in[g]),
      .pad_out (pad_gpio_out[g]),
      .pad_oe  (pad_gpio_oe[g])
    );
  end

  for (genvar c = 0; c < N_CFG; c++) begin : g_cfg
    bscan_obs_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .clk_dr(capture_dr),
      .shift (shift_dr),
      .par_in(pad_cfg_in[c]),
      .ser_in(ser_vec[CFG_BASE+c]),
      .cap_q (cap_q[CFG_BASE+c])
    );
  end

  for (genvar m = 0; m < N_MEM; m++) begin : g_mem
    bscan_mem_pin u_pin (
      .clk     (clk),
      .rst     (rst),
      .clk_dr  (capture_dr),
      .shift   (shift_dr),
      .upd_dr  (update_dr),
      .extest  (extest),
      .ser_in  (ser_vec[MEM_BASE+m*MEM_CELLS +: MEM_CELLS]),
      .cap_q   (cap_q[MEM_BASE+m*MEM_CELLS +: MEM_CELLS]),
      .core_out(core_mem_out[m]),
      .core_oe (core_mem_oe[m]),
      .pad_in  (pad_mem_in[m]),
      .pad_out (pad_mem_out[m]),
      .pad_oe  (pad_mem_oe[m])
    );
  end
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk
  import bscan_pkg::*;
#(
  parameter int N_GPIO = 2,
  parameter int N_CFG  = 2,
  parameter int N_MEM  = 2,
  parameter int LEN    = chain_len(N_GPIO, N_CFG, N_MEM)
) (
  input logic              clk,
  input logic              rst,
  input logic              capture_dr,
  input logic              shift_dr,
  input logic              update_dr,
  input logic              extest,
  input logic              tdo,
  input logic [N_CFG-1:0]  pad_cfg_in,
  input logic [N_GPIO-1:0] pad_gpio_out,
  input logic [N_GPIO-1:0] pad_gpio_oe,
  input logic [N_MEM-1:0]  pad_mem_out,
  input logic [N_MEM-1:0]  pad_mem_oe,
  input logic [LEN-1:0]    cap_q
);
  localparam int CFG_BASE = cfg_base(N_GPIO);
  localparam int MEM_BASE = mem_base(N_GPIO, N_CFG);

  // R1: each shift edge moves every bit one place toward tdo
  p_shift_move_r1: assert property (@(posedge clk) disable iff (rst)
    capture_dr && shift_dr |=> cap_q[LEN-2:0] == $past(cap_q[LEN-1:1]));

  // R3: configuration cells take the pad state on capture
  p_cfg_capture_r3: assert property (@(posedge clk) disable iff (rst)
    capture_dr && !shift_dr |=> cap_q[CFG_BASE +: N_CFG] == $past(pad_cfg_in));

  // R5: memory data cells ignore the pad when capturing in external-test mode
  for (genvar m = 0; m < N_MEM; m++) begin : g_memchk
    p_mem_hold_r5: assert property (@(posedge clk) disable iff (rst)
      capture_dr && !shift_dr && extest |=>
        cap_q[MEM_BASE+m*MEM_CELLS+MEM_IO] == $past(cap_q[MEM_BASE+m*MEM_CELLS+MEM_IO]));
  end

  // R8: pads are frozen in external-test mode without an update edge
  p_pad_freeze_r8: assert property (@(posedge clk) disable iff (rst)
    extest && $past(extest) && !$past(update_dr) |->
      $stable(pad_gpio_out) && $stable(pad_gpio_oe) &&
      $stable(pad_mem_out) && $stable(pad_mem_oe));

  // R9: after reset the serial output and all driven pad values are low
  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && extest |->
      !tdo && pad_gpio_out == '0 && pad_gpio_oe == '0 &&
      pad_mem_out == '0 && pad_mem_oe == '0);

  // R10: no clock enable, no change in the capture stage
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !capture_dr |=> $stable(cap_q));
endmodule

bind bscan_chain bscan_chain_chk #(
  .N_GPIO(N_GPIO), .N_CFG(N_CFG), .N_MEM(N_MEM)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .capture_dr  (capture_dr),
  .shift_dr    (shift_dr),
  .update_dr   (update_dr),
  .extest      (extest),
  .tdo         (tdo),
  .pad_cfg_in  (pad_cfg_in),
  .pad_gpio_out(pad_gpio_out),
  .pad_gpio_oe (pad_gpio_oe),
  .pad_mem_out (pad_mem_out),
  .pad_mem_oe  (pad_mem_oe),
  .cap_q       (cap_q)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;
  localparam int CLK_P  = 10;
  localparam int NG     = 2;
  localparam int NC     = 2;
  localparam int NM     = 2;
  localparam int N      = 3*NG + NC + 2*NM;
  localparam int CB     = 3*NG;
  localparam int MB     = 3*NG + NC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, extest = 1'b0, tdi = 1'b0;
  logic tdo;
  logic [NG-1:0] core_gpio_out = '0, core_gpio_oe = '0, pad_gpio_in = '0;
  logic [NG-1:0] pad_gpio_out, pad_gpio_oe;
  logic [NC-1:0] pad_cfg_in = '0;
  logic [NM-1:0] core_mem_out = '0, core_mem_oe = '0, pad_mem_in = '0;
  logic [NM-1:0] pad_mem_out, pad_mem_oe;

  always #(CLK_P/2) clk = ~clk;

  bscan_chain #(.N_GPIO(NG), .N_CFG(NC), .N_MEM(NM)) uut (
    .clk(clk), .rst(rst), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .extest(extest), .tdi(tdi), .tdo(tdo),
    .core_gpio_out(core_gpio_out), .core_gpio_oe(core_gpio_oe),
    .pad_gpio_in(pad_gpio_in), .pad_gpio_out(pad_gpio_out), .pad_gpio_oe(pad_gpio_oe),
    .pad_cfg_in(pad_cfg_in), .core_mem_out(core_mem_out), .core_mem_oe(core_mem_oe),
    .pad_mem_in(pad_mem_in), .pad_mem_out(pad_mem_out), .pad_mem_oe(pad_mem_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model of the chain, built from the requirements
  logic [N-1:0] mcap = '0;
  logic [N-1:0] mupd = '0;
  string        mtag [N];

  // scoreboard queues
  bit    q_exp [$];
  string q_tag [$];
  bit    mon_en = 1'b0;
  int    bitpos = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: sample tdo a quarter period after the driving edge
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (mon_en) begin
      if (q_exp.size() == 0) begin
        check("R1 queue underrun", 32'd1, 32'd0);
      end else begin
        bit    e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check($sformatf("%s tdo bit %0d", t, bitpos), {31'd0, tdo}, {31'd0, e});
      end
      bitpos++;
    end
  end

  task automatic do_capture();
    @(negedge clk);
    for (int g = 0; g < NG; g++) begin
      mcap[3*g]   = pad_gpio_in[g];    mtag[3*g]   = "R2";
      mcap[3*g+1] = core_gpio_out[g];  mtag[3*g+1] = "R2";
      mcap[3*g+2] = core_gpio_oe[g];   mtag[3*g+2] = "R2";
    end
    for (int c = 0; c < NC; c++) begin
      mcap[CB+c] = pad_cfg_in[c]; mtag[CB+c] = "R3";
    end
    for (int m = 0; m < NM; m++) begin
      if (!extest) begin
        mcap[MB+2*m] = pad_mem_in[m]; mtag[MB+2*m] = "R4";
      end else begin
        mtag[MB+2*m] = "R5";
      end
      mcap[MB+2*m+1] = core_mem_oe[m]; mtag[MB+2*m+1] = "R4";
    end
    capture_dr = 1'b1;
    shift_dr   = 1'b0;
    @(negedge clk);
    capture_dr = 1'b0;
  endtask

  // driver: push the expected frame, then shift a new one in
  task automatic do_shift(input logic [N-1:0] vec);
    for (int i = 0; i < N; i++) begin
      q_exp.push_back(mcap[i]);
      q_tag.push_back(mtag[i]);
    end
    bitpos = 0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      capture_dr = 1'b1;
      shift_dr   = 1'b1;
      tdi        = vec[i];
      mon_en     = 1'b1;
    end
    @(negedge clk);
    capture_dr = 1'b0;
    shift_dr   = 1'b0;
    mon_en     = 1'b0;
    mcap = vec;
    for (int i = 0; i < N; i++) mtag[i] = "R1";
  endtask

  task automatic do_update();
    @(negedge clk);
    update_dr = 1'b1;
    @(negedge clk);
    update_dr = 1'b0;
    mupd = mcap;
  endtask

  task automatic check_pads(input string tag);
    logic [NG-1:0] eg_o, eg_e;
    logic [NM-1:0] em_o, em_e;
    #1;
    for (int g = 0; g < NG; g++) begin
      eg_o[g] = extest ? mupd[3*g+1] : core_gpio_out[g];
      eg_e[g] = extest ? mupd[3*g+2] : core_gpio_oe[g];
    end
    for (int m = 0; m < NM; m++) begin
      em_o[m] = extest ? mupd[MB+2*m]   : core_mem_out[m];
      em_e[m] = extest ? mupd[MB+2*m+1] : core_mem_oe[m];
    end
    check({tag, " pad_gpio_out"}, 32'(pad_gpio_out), 32'(eg_o));
    check({tag, " pad_gpio_oe"},  32'(pad_gpio_oe),  32'(eg_e));
    check({tag, " pad_mem_out"},  32'(pad_mem_out),  32'(em_o));
    check({tag, " pad_mem_oe"},   32'(pad_mem_oe),   32'(em_e));
  endtask

  task automatic set_inputs(input logic [11:0] p);
    @(negedge clk);
    core_gpio_out = p[1:0];
    core_gpio_oe  = p[3:2];
    pad_gpio_in   = p[5:4];
    pad_cfg_in    = p[7:6];
    pad_mem_in    = p[9:8];
    core_mem_oe   = p[11:10];
    core_mem_out  = ~p[1:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mcap = '0;
    mupd = '0;
    for (int i = 0; i < N; i++) mtag[i] = "R9";
  endtask

  initial begin
    for (int i = 0; i < N; i++) mtag[i] = "R9";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R9 tdo after reset", 32'(tdo), 32'd0);
    extest = 1'b1;
    check_pads("R9 pads after reset");
    extest = 1'b0;

    // sample path with pattern 1
    set_inputs(12'b11_10_01_11_01_10);
    check_pads("R7 pads follow core");
    do_capture();
    do_shift(12'hA5C);
    check_pads("R7 pads follow core after preload");

    // update flops still cleared until the update strobe
    extest = 1'b1;
    check_pads("R6 pads before update");
    do_update();
    check_pads("R8 pads from preload");

    set_inputs(12'b01_01_10_10_10_01);
    check_pads("R8 pads ignore core changes");

    // capture in external-test mode: memory data cells keep preload
    do_capture();
    do_shift(12'h3C9);
    check_pads("R6 update flops unchanged by shift");
    do_update();
    check_pads("R8 pads from second frame");

    // sampling, then idle cycles with changing inputs
    extest = 1'b0;
    do_capture();
    for (int i = 0; i < N; i++) mtag[i] = "R10";
    set_inputs(12'b10_01_10_01_00_11);
    repeat (4) @(negedge clk);
    set_inputs(12'b00_11_01_10_11_00);
    do_shift(12'h000);
    check_pads("R7 pads follow core pattern 3");

    // reset while update flops hold data
    do_update();
    do_reset();
    extest = 1'b1;
    #1;
    check("R9 tdo after second reset", 32'(tdo), 32'd0);
    check_pads("R9 pads after second reset");

    check("R1 scoreboard drained", 32'(q_exp.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule